// File: doc/BRIEF.md
# IO Freeze and Thaw Sequencer

This block is a hardware state machine that moves a group of IO channels between a safe frozen condition and normal operation. A single request port carries a strobe, a direction bit and a channel index. Once a request is accepted, the block applies a fixed, ordered list of steps to the control lines of that one channel. Between two steps it enforces a minimum gap, counted in clock cycles derived from a clock-frequency parameter. In one place, the gap is counted in ticks of a slow oscillator instead.

There are `NUM_STD` identical standard channels, numbered 0 to `NUM_STD-1`, and one extended channel with index `NUM_STD`. The extended channel also drives register-freeze, termination-reset, DLL-reset and calibration-enable lines. Its thaw includes two waits counted on `osc_tick`. The controls have mixed polarity: slew, pull-up, tristate and bus-hold enables are active-low, and the other lines are active-high.

The state machine has these states:

- `FS_IDLE`: waiting for a request.
- `FS_SF_W1`: standard freeze, the gap after step 1.
- `FS_ST_W1` and `FS_ST_W2`: standard thaw, the gaps after steps 1 and 2.
- `FS_XF_W1` and `FS_XF_W2`: extended freeze, the gaps after steps 1 and 2.
- `FS_XT_W1` to `FS_XT_W5`: extended thaw, the waits after steps 1 to 5.

The first step is applied on the edge that leaves `FS_IDLE`. Each wait state applies the next step on the edge where its count expires. The final step returns the machine to `FS_IDLE` and raises `done`.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset, every channel is thawed. The active-low enables (`slew_n`, `pull_n`, `tri_n`, `hold_n`) are 1 and `cfg_done` is 1. `frz_reg`, `oct_rst` and `dll_rst` are 0, and `cal_en` is 1. `busy`, `done`, `err` and `sw_src` are 0.
- R2: Freezing a standard channel (`thaw`=0) takes two steps.
  - Step 1 is on the accepting edge: slew, pull-up and tristate go to 0.
  - Step 2 comes `GAP_STD` = ceil(20 ns x `CLK_MHZ`/1000) cycles later (4 at 200 MHz): `hold_n` goes to 0 and `cfg_done` goes to 0.
- R3: Thawing a standard channel (`thaw`=1) takes three steps, `GAP_STD` cycles apart.
  - Step 1 is on the accepting edge: `hold_n` and `cfg_done` go to 1.
  - Step 2: `pull_n` and `tri_n` go to 1.
  - Step 3: `slew_n` goes to 1.
- R4: Freezing the extended channel takes three steps, `GAP_EXT` = ceil(40 ns x `CLK_MHZ`/1000) cycles apart (8 at 200 MHz).
  - Step 1: slew, pull-up and tristate go to 0.
  - Step 2: `hold_n`=0, `cfg_done`=0, `frz_reg`=1 and `oct_rst`=1.
  - Step 3: `cal_en`=0 and `dll_rst`=1.
- R5: The extended thaw begins as follows.
  - It clears `dll_rst` on the accepting edge.
  - `GAP_EXT` cycles later, it sets `cal_en`.
  - It then waits for `OSC_LONG` (1000) rising-edge-sampled `osc_tick` cycles. This wait counts ticks, not clocks.
- R6: After the long wait, the extended thaw continues.
  - In one step: `hold_n`=1, `cfg_done`=1 and `oct_rst`=0.
  - `OSC_SHORT` (33) ticks later: `pull_n`=1 and `tri_n`=1.
  - `GAP_EXT` cycles later: `frz_reg`=0.
  - `GAP_EXT` cycles later: `slew_n`=1.
- R7: A request whose index is above `NUM_STD` gives a one-cycle `err` pulse on the next edge. It changes no control line, `busy` or `sw_src`.
- R8: `busy` is 1 from the accepting edge until the edge of the final step. On that edge `busy` falls and `done` is 1 for exactly one cycle.
- R9: A request made while `busy` is 1 is dropped. It is not queued, and it touches no channel.
- R10: `sw_src` is 0 after reset. It becomes 1, meaning software-started, on the first accepted request and stays 1.
- R11: Only the requested channel's lines change. Every other channel keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled when idle |
| thaw | input | 1 | 1 = thaw, 0 = freeze |
| chan | input | CH_W (3) | Channel index |
| osc_tick | input | 1 | Oscillator tick enable for the long and short waits |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse on the final step |
| err | output | 1 | One-cycle pulse for an invalid index |
| sw_src | output | 1 | Sequence source: 1 = software request |
| slew_n | output | NUM_STD+1 | Per-channel slew enable, active-low |
| pull_n | output | NUM_STD+1 | Per-channel weak pull-up enable, active-low |
| tri_n | output | NUM_STD+1 | Per-channel tristate enable, active-low |
| hold_n | output | NUM_STD+1 | Per-channel bus-hold enable, active-low |
| cfg_done | output | NUM_STD+1 | Per-channel configuration-done |
| frz_reg | output | 1 | Extended channel register freeze |
| oct_rst | output | 1 | Extended channel termination reset |
| dll_rst | output | 1 | Extended channel DLL reset |
| cal_en | output | 1 | Extended channel calibration-start/bias enable |

## Verification
Each of the four sequence kinds is stepped through cycle by cycle. The expected step edge and the cycle just before it are both sampled, which separates a correct gap from a gap that is one cycle short or long.

A stimulus table interleaves freezes, thaws and invalid indexes across all channels, and compares every line against a frozen-channel model. This catches a wrong channel decode and any cross-channel disturbance.

A request injected mid-sequence tells a dropped request apart from a queued one. An extended thaw with `osc_tick` at half rate shows whether the long wait counts ticks or clocks.

// File: rtl/io_frz_pkg.sv
package io_frz_pkg;

    typedef enum logic [3:0] {
        FS_IDLE,
        FS_SF_W1,
        FS_ST_W1,
        FS_ST_W2,
        FS_XF_W1,
        FS_XF_W2,
        FS_XT_W1,
        FS_XT_W2,
        FS_XT_W3,
        FS_XT_W4,
        FS_XT_W5
    } fsm_state_e;

    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_SF1,
        ACT_SF2,
        ACT_ST1,
        ACT_ST2,
        ACT_ST3,
        ACT_XF1,
        ACT_XF2,
        ACT_XF3,
        ACT_XT1,
        ACT_XT2,
        ACT_XT3,
        ACT_XT4,
        ACT_XT5,
        ACT_XT6
    } step_act_e;

    typedef enum logic [1:0] {
        WAIT_STD,
        WAIT_EXT,
        WAIT_OSC_LONG,
        WAIT_OSC_SHORT
    } wait_kind_e;

    typedef struct packed {
        logic slew_n;
        logic pull_n;
        logic tri_n;
        logic hold_n;
        logic cfg_done;
    } io_ctrl_t;

    // Minimum gap in clock cycles, rounded up, never below one cycle
    function automatic int gap_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/io_frz_timer.sv
module io_frz_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expires on the increment that completes 'limit' counts
    assign hit = inc && (cnt == limit - 1'b1);

endmodule

// File: rtl/io_frz_fsm.sv
module io_frz_fsm
    import io_frz_pkg::*;
#(
    parameter int CH_W      = 3,
    parameter int NUM_STD   = 3,
    parameter int GAP_STD   = 4,
    parameter int GAP_EXT   = 8,
    parameter int OSC_LONG  = 1000,
    parameter int OSC_SHORT = 33,
    parameter int CNT_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             thaw,
    input  logic [CH_W-1:0]  chan,
    input  logic             osc_tick,
    input  logic             hit,
    output logic             tmr_clr,
    output logic             tmr_inc,
    output logic [CNT_W-1:0] tmr_limit,
    output step_act_e        act,
    output logic [CH_W-1:0]  act_chan,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             sw_src
);

    localparam logic [CH_W-1:0]  EXT_IDX   = CH_W'(NUM_STD);
    localparam logic [CNT_W-1:0] LIM_STD   = CNT_W'(GAP_STD);
    localparam logic [CNT_W-1:0] LIM_EXT   = CNT_W'(GAP_EXT);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(OSC_LONG);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(OSC_SHORT);

    fsm_state_e      state, nxt;
    wait_kind_e      kind;
    logic [CH_W-1:0] ch_q;
    logic            accept, reject, finish;
    logic            chan_ok, chan_ext;

    assign chan_ok  = (chan <= EXT_IDX);
    assign chan_ext = (chan == EXT_IDX);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            ch_q  <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                ch_q <= chan;
            end
        end
    end

    // Next state and step selection
    always_comb begin
        nxt    = state;
        act    = ACT_NONE;
        accept = 1'b0;
        reject = 1'b0;
        finish = 1'b0;
        unique case (state)
            FS_IDLE: begin
                if (req) begin
                    if (!chan_ok) begin
                        reject = 1'b1;
                    end else begin
                        accept = 1'b1;
                        if (chan_ext && thaw) begin
                            nxt = FS_XT_W1;
                            act = ACT_XT1;
                        end else if (chan_ext) begin
                            nxt = FS_XF_W1;
                            act = ACT_XF1;
                        end else if (thaw) begin
                            nxt = FS_ST_W1;
                            act = ACT_ST1;
                        end else begin
                            nxt = FS_SF_W1;
                            act = ACT_SF1;
                        end
                    end
                end
            end
            FS_SF_W1: begin
                if (hit) begin
                    act    = ACT_SF2;
                    nxt    = FS_IDLE;
                    finish = 1'b1;
                end
            end
            FS_ST_W1: begin
                if (hit) begin
                    act = ACT_ST2;
                    nxt = FS_ST_W2;
                end
            end
            FS_ST_W2: begin
                if (hit) begin
                    act    = ACT_ST3;
                    nxt    = FS_IDLE;
                    finish = 1'b1;
                end
            end
            FS_XF_W1: begin
                if (hit) begin
                    act = ACT_XF2;
                    nxt = FS_XF_W2;
                end
            end
            FS_XF_W2: begin
                if (hit) begin
                    act    = ACT_XF3;
                    nxt    = FS_IDLE;
                    finish = 1'b1;
                end
            end
            FS_XT_W1: begin
                if (hit) begin
                    act = ACT_XT2;
                    nxt = FS_XT_W2;
                end
            end
            FS_XT_W2: begin
                if (hit) begin
                    act = ACT_XT3;
                    nxt = FS_XT_W3;
                end
            end
            FS_XT_W3: begin
                if (hit) begin
                    act = ACT_XT4;
                    nxt = FS_XT_W4;
                end
            end
            FS_XT_W4: begin
                if (hit) begin
                    act = ACT_XT5;
                    nxt = FS_XT_W5;
                end
            end
            FS_XT_W5: begin
                if (hit) begin
                    act    = ACT_XT6;
                    nxt    = FS_IDLE;
                    finish = 1'b1;
                end
            end
            default: begin
                nxt = FS_IDLE;
            end
        endcase
    end

    // Wait source for the current state
    always_comb begin
        unique case (state)
            FS_SF_W1, FS_ST_W1, FS_ST_W2: kind = WAIT_STD;
            FS_XT_W2:                     kind = WAIT_OSC_LONG;
            FS_XT_W3:                     kind = WAIT_OSC_SHORT;
            default:                      kind = WAIT_EXT;
        endcase
    end

    always_comb begin
        unique case (kind)
            WAIT_STD:       tmr_limit = LIM_STD;
            WAIT_EXT:       tmr_limit = LIM_EXT;
            WAIT_OSC_LONG:  tmr_limit = LIM_LONG;
            WAIT_OSC_SHORT: tmr_limit = LIM_SHORT;
            default:        tmr_limit = LIM_EXT;
        endcase
    end

    assign tmr_inc  = (kind == WAIT_OSC_LONG || kind == WAIT_OSC_SHORT) ? osc_tick : 1'b1;
    assign tmr_clr  = (state == FS_IDLE) || (nxt != state);
    assign act_chan = accept ? chan : ch_q;
    assign busy     = (state != FS_IDLE);

    // Flag outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            err    <= 1'b0;
            sw_src <= 1'b0;
        end else begin
            done <= finish;
            err  <= reject;
            if (accept) begin
                sw_src <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/io_frz_std_bank.sv
module io_frz_std_bank
    import io_frz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      apply,
    input  step_act_e act,
    output io_ctrl_t  ctrl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '1;
        end else if (apply) begin
            case (act)
                ACT_SF1: begin
                    ctrl.slew_n <= 1'b0;
                    ctrl.pull_n <= 1'b0;
                    ctrl.tri_n  <= 1'b0;
                end
                ACT_SF2: begin
                    ctrl.hold_n   <= 1'b0;
                    ctrl.cfg_done <= 1'b0;
                end
                ACT_ST1: begin
                    ctrl.hold_n   <= 1'b1;
                    ctrl.cfg_done <= 1'b1;
                end
                ACT_ST2: begin
                    ctrl.pull_n <= 1'b1;
                    ctrl.tri_n  <= 1'b1;
                end
                ACT_ST3: begin
                    ctrl.slew_n <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/io_frz_ext_bank.sv
module io_frz_ext_bank
    import io_frz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      apply,
    input  step_act_e act,
    output io_ctrl_t  ctrl,
    output logic      frz_reg,
    output logic      oct_rst,
    output logic      dll_rst,
    output logic      cal_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '1;
            frz_reg <= 1'b0;
            oct_rst <= 1'b0;
            dll_rst <= 1'b0;
            cal_en  <= 1'b1;
        end else if (apply) begin
            case (act)
                ACT_XF1: begin
                    ctrl.slew_n <= 1'b0;
                    ctrl.pull_n <= 1'b0;
                    ctrl.tri_n  <= 1'b0;
                end
                ACT_XF2: begin
                    ctrl.hold_n   <= 1'b0;
                    ctrl.cfg_done <= 1'b0;
                    frz_reg       <= 1'b1;
                    oct_rst       <= 1'b1;
                end
                ACT_XF3: begin
                    cal_en  <= 1'b0;
                    dll_rst <= 1'b1;
                end
                ACT_XT1: begin
                    dll_rst <= 1'b0;
                end
                ACT_XT2: begin
                    cal_en <= 1'b1;
                end
                ACT_XT3: begin
                    ctrl.hold_n   <= 1'b1;
                    ctrl.cfg_done <= 1'b1;
                    oct_rst       <= 1'b0;
                end
                ACT_XT4: begin
                    ctrl.pull_n <= 1'b1;
                    ctrl.tri_n  <= 1'b1;
                end
                ACT_XT5: begin
                    frz_reg <= 1'b0;
                end
                ACT_XT6: begin
                    ctrl.slew_n <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/io_freeze_seq.sv
module io_freeze_seq
    import io_frz_pkg::*;
#(
    parameter int CLK_MHZ    = 200,
    parameter int STD_GAP_NS = 20,
    parameter int EXT_GAP_NS = 40,
    parameter int OSC_LONG   = 1000,
    parameter int OSC_SHORT  = 33,
    parameter int NUM_STD    = 3,
    parameter int CH_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              thaw,
    input  logic [CH_W-1:0]   chan,
    input  logic              osc_tick,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              sw_src,
    output logic [NUM_STD:0]  slew_n,
    output logic [NUM_STD:0]  pull_n,
    output logic [NUM_STD:0]  tri_n,
    output logic [NUM_STD:0]  hold_n,
    output logic [NUM_STD:0]  cfg_done,
    output logic              frz_reg,
    output logic              oct_rst,
    output logic              dll_rst,
    output logic              cal_en
);

    localparam int NCH     = NUM_STD + 1;
    localparam int GAP_STD = gap_cycles(STD_GAP_NS, CLK_MHZ);
    localparam int GAP_EXT = gap_cycles(EXT_GAP_NS, CLK_MHZ);
    localparam int MAX_A   = (GAP_STD > GAP_EXT) ? GAP_STD : GAP_EXT;
    localparam int MAX_B   = (OSC_LONG > OSC_SHORT) ? OSC_LONG : OSC_SHORT;
    localparam int MAX_LIM = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic             tmr_clr, tmr_inc, tmr_hit;
    logic [CNT_W-1:0] tmr_limit;
    step_act_e        act;
    logic [CH_W-1:0]  act_chan;
    io_ctrl_t         ctrl [NCH];

    io_frz_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    io_frz_fsm #(
        .CH_W      (CH_W),
        .NUM_STD   (NUM_STD),
        .GAP_STD   (GAP_STD),
        .GAP_EXT   (GAP_EXT),
        .OSC_LONG  (OSC_LONG),
        .OSC_SHORT (OSC_SHORT),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .thaw      (thaw),
        .chan      (chan),
        .osc_tick  (osc_tick),
        .hit       (tmr_hit),
        .tmr_clr   (tmr_clr),
        .tmr_inc   (tmr_inc),
        .tmr_limit (tmr_limit),
        .act       (act),
        .act_chan  (act_chan),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .sw_src    (sw_src)
    );

    for (genvar i = 0; i < NUM_STD; i++) begin : g_std
        io_frz_std_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .apply (act_chan == CH_W'(i)),
            .act   (act),
            .ctrl  (ctrl[i])
        );
    end

    io_frz_ext_bank u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .apply   (act_chan == CH_W'(NUM_STD)),
        .act     (act),
        .ctrl    (ctrl[NUM_STD]),
        .frz_reg (frz_reg),
        .oct_rst (oct_rst),
        .dll_rst (dll_rst),
        .cal_en  (cal_en)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_out
        assign slew_n[i]   = ctrl[i].slew_n;
        assign pull_n[i]   = ctrl[i].pull_n;
        assign tri_n[i]    = ctrl[i].tri_n;
        assign hold_n[i]   = ctrl[i].hold_n;
        assign cfg_done[i] = ctrl[i].cfg_done;
    end

endmodule

// File: rtl/io_freeze_chk.sv
module io_freeze_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           err,
    input logic           sw_src,
    input logic [NCH-1:0] slew_n,
    input logic [NCH-1:0] pull_n,
    input logic [NCH-1:0] tri_n,
    input logic [NCH-1:0] hold_n,
    input logic [NCH-1:0] cfg_done,
    input logic           frz_reg,
    input logic           oct_rst,
    input logic           dll_rst,
    input logic           cal_en
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && $stable(slew_n) && $stable(hold_n) && $stable(cfg_done)
                 && $stable(dll_rst) && $stable(sw_src)));

    // R10
    src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> !$fell(sw_src));

    // R2
    std_hold_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_n[0]) |-> (!slew_n[0] && !pull_n[0] && !tri_n[0]));

    // R3
    std_slew_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slew_n[0]) |-> (pull_n[0] && tri_n[0] && hold_n[0] && cfg_done[0]));

    // R4
    ext_dll_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_rst) |-> (frz_reg && oct_rst && !hold_n[NCH-1] && !cal_en));

    // R6
    ext_slew_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slew_n[NCH-1]) |-> (!frz_reg && !oct_rst && pull_n[NCH-1] && hold_n[NCH-1]));

endmodule

bind io_freeze_seq io_freeze_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_io_freeze_seq.sv
`timescale 1ns/1ps
module sim_io_freeze_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       thaw = 1'b0;
    logic [2:0] chan = 3'd0;
    logic       osc_tick = 1'b1;
    logic       osc_slow = 1'b0;

    logic       busy, done, err, sw_src;
    logic [3:0] slew_n, pull_n, tri_n, hold_n, cfg_done;
    logic       frz_reg, oct_rst, dll_rst, cal_en;

    int checks = 0;
    int errors = 0;

    // {thaw, chan, cycles to done, expect err}
    localparam logic [15:0] VECS [12] = '{
        {1'b0, 3'd0, 11'd4,    1'b0},
        {1'b0, 3'd2, 11'd4,    1'b0},
        {1'b0, 3'd7, 11'd0,    1'b1},
        {1'b1, 3'd0, 11'd8,    1'b0},
        {1'b0, 3'd3, 11'd16,   1'b0},
        {1'b0, 3'd1, 11'd4,    1'b0},
        {1'b1, 3'd3, 11'd1057, 1'b0},
        {1'b1, 3'd5, 11'd0,    1'b1},
        {1'b1, 3'd2, 11'd8,    1'b0},
        {1'b1, 3'd1, 11'd8,    1'b0},
        {1'b0, 3'd0, 11'd4,    1'b0},
        {1'b1, 3'd0, 11'd8,    1'b0}
    };

    io_freeze_seq u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .thaw     (thaw),
        .chan     (chan),
        .osc_tick (osc_tick),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .sw_src   (sw_src),
        .slew_n   (slew_n),
        .pull_n   (pull_n),
        .tri_n    (tri_n),
        .hold_n   (hold_n),
        .cfg_done (cfg_done),
        .frz_reg  (frz_reg),
        .oct_rst  (oct_rst),
        .dll_rst  (dll_rst),
        .cal_en   (cal_en)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) osc_tick <= osc_slow ? ~osc_tick : 1'b1;

    function automatic logic [23:0] model(input logic [3:0] fz);
        return {~fz, ~fz, ~fz, ~fz, ~fz, fz[3], fz[3], fz[3], ~fz[3]};
    endfunction

    function logic [23:0] outs();
        return {slew_n, pull_n, tri_n, hold_n, cfg_done, frz_reg, oct_rst, dll_rst, cal_en};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic th, input logic [2:0] c);
        req  = 1'b1;
        thaw = th;
        chan = c;
        @(negedge clk);
        req  = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0] fz;
        int t;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs after reset", outs(), model(4'b0000));
        chk("R1 busy after reset", busy, 0);
        chk("R1 done/err after reset", {done, err}, 0);
        chk("R10 sw_src after reset", sw_src, 0);

        // R7 invalid index
        issue(1'b0, 3'd4);
        chk("R7 err pulse", err, 1);
        chk("R7 busy stays low", busy, 0);
        chk("R7 outputs untouched", outs(), model(4'b0000));
        chk("R7 sw_src untouched", sw_src, 0);
        step(1);
        chk("R7 err one cycle", err, 0);

        // R2 standard freeze on channel 1
        issue(1'b0, 3'd1);
        chk("R2 step1 slew", slew_n, 4'b1101);
        chk("R2 step1 pull/tri", {pull_n, tri_n}, 8'b1101_1101);
        chk("R2 step1 hold unchanged", hold_n, 4'b1111);
        chk("R8 busy after accept", busy, 1);
        chk("R10 sw_src set", sw_src, 1);
        step(3);
        chk("R2 hold before gap", hold_n, 4'b1111);
        chk("R8 no early done", {busy, done}, 2'b10);
        step(1);
        chk("R2 step2 hold/cfg", {hold_n, cfg_done}, 8'b1101_1101);
        chk("R8 done with busy low", {busy, done}, 2'b01);
        chk("R11 only channel 1 frozen", outs(), model(4'b0010));
        step(1);
        chk("R8 done one cycle", done, 0);

        // R3 standard thaw on channel 1
        issue(1'b1, 3'd1);
        chk("R3 step1 hold/cfg", {hold_n, cfg_done}, 8'b1111_1111);
        chk("R3 step1 pull still low", pull_n, 4'b1101);
        step(3);
        chk("R3 pull before gap", pull_n, 4'b1101);
        step(1);
        chk("R3 step2 pull/tri", {pull_n, tri_n, slew_n}, 12'b1111_1111_1101);
        step(3);
        chk("R3 slew before gap", slew_n, 4'b1101);
        step(1);
        chk("R3 step3 slew", slew_n, 4'b1111);
        chk("R8 thaw done", {busy, done}, 2'b01);
        chk("R3 all thawed", outs(), model(4'b0000));
        step(1);

        // R4 extended freeze, R9 request while busy
        issue(1'b0, 3'd3);
        chk("R4 step1 slew/pull/tri", {slew_n, pull_n, tri_n}, 12'b0111_0111_0111);
        chk("R4 step1 frz low", {hold_n, frz_reg}, 5'b1111_0);
        req  = 1'b1;
        thaw = 1'b0;
        chan = 3'd0;
        @(negedge clk);
        req  = 1'b0;
        step(6);
        chk("R4 step2 not before gap", {hold_n, frz_reg}, 5'b1111_0);
        step(1);
        chk("R4 step2", {hold_n, cfg_done, frz_reg, oct_rst, dll_rst, cal_en}, 12'b0111_0111_1101);
        step(7);
        chk("R4 step3 not before gap", {dll_rst, busy}, 2'b01);
        step(1);
        chk("R4 step3 dll/cal", {dll_rst, cal_en}, 2'b10);
        chk("R8 ext freeze done", {busy, done}, 2'b01);
        chk("R9 channel 0 untouched", slew_n[0], 1);
        chk("R4 frozen state", outs(), model(4'b1000));
        step(2);
        chk("R9 request not queued", busy, 0);
        chk("R9 state after drop", outs(), model(4'b1000));

        // R5 and R6 extended thaw, tick every clock
        issue(1'b1, 3'd3);
        chk("R5 step1 dll cleared", {dll_rst, cal_en, busy}, 3'b001);
        step(7);
        chk("R5 cal before gap", cal_en, 0);
        step(1);
        chk("R5 cal set", cal_en, 1);
        step(999);
        chk("R5 hold held through long wait", hold_n, 4'b0111);
        step(1);
        chk("R6 hold/cfg/oct step", {hold_n, cfg_done, oct_rst}, 9'b1111_1111_0);
        chk("R6 pull still low", pull_n, 4'b0111);
        step(32);
        chk("R6 pull before short wait", pull_n, 4'b0111);
        step(1);
        chk("R6 pull/tri released", {pull_n, tri_n, frz_reg}, 9'b1111_1111_1);
        step(7);
        chk("R6 frz before gap", frz_reg, 1);
        step(1);
        chk("R6 frz cleared", {frz_reg, slew_n}, 5'b0_0111);
        step(7);
        chk("R6 slew before gap", {slew_n, busy}, 5'b0111_1);
        step(1);
        chk("R6 slew released", slew_n, 4'b1111);
        chk("R8 ext thaw done", {busy, done}, 2'b01);
        chk("R6 all thawed", outs(), model(4'b0000));
        step(1);

        // R5 long wait counts osc ticks, not clocks
        issue(1'b0, 3'd3);
        step(17);
        osc_slow = 1'b1;
        issue(1'b1, 3'd3);
        step(1008);
        chk("R5 wait counts ticks", hold_n, 4'b0111);
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk("R5 slow thaw completes", done, 1);
        chk("R5 slow thaw result", outs(), model(4'b0000));
        osc_slow = 1'b0;
        step(2);

        // table of vectors
        fz = 4'b0000;
        for (int i = 0; i < 12; i++) begin
            logic [15:0] v;
            v = VECS[i];
            issue(v[15], v[14:12]);
            t = 0;
            while (!done && !err && t < 3000) begin
                @(negedge clk);
                t++;
            end
            chk("R7 err flag for vector", err, v[0]);
            chk("R8 cycles to completion", t, 32'(v[11:1]));
            if (!v[0]) fz[v[14:12]] = ~v[15];
            chk("R11 outputs after vector", outs(), model(fz));
            step(1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule